// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a clock-multiplying PLL through a full reprogramming run after a single start pulse. It takes a target multiplier, reference divider and output divider. It drives the PLL's control pins (bias enable, clock-mux enable, bypass, power-down and reset) and writes the encoded configuration fields that the PLL reads. Every wait between two control changes is counted in reference-clock cycles. The resulting PLL output is the reference frequency times the multiplier, divided by the reference divider and then by the output divider. For example, 122.88 MHz × 16 / 1 / 2 gives 983.04 MHz.

The run takes one of two paths. If bypass is still set, as it is after power-up, the block takes the cold path: it biases the PLL and power-cycles it. If bypass is already clear because the PLL locked earlier, it takes the warm path and only moves the clock mux off the PLL before reprogramming. Both paths then do the same things in order:
- trigger a divider-bank update through a request/busy handshake;
- pulse the PLL reset;
- wait for lock;
- clear bypass, then enable the clock mux.

A start is accepted only while two key slots hold the unlock values. The block clears both key slots itself when the run ends.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, bypass is 1. bias_en, mux_en, pwr_dn, pll_rst, go_req, busy, done, err and every field output are 0.
- R2: start has an effect only when the block is idle, key slot 0 (key_sel=0) holds KEY0 and key slot 1 (key_sel=1) holds KEY1. Otherwise busy stays 0 and no control pin changes. Writing any other value to either slot locks the block again.
- R3: Cold path (bypass=1 when start is accepted). bias_en rises on the accepting edge and mux_en is cleared one cycle later. bypass is held set MUX_CYC cycles after that. pwr_dn rises one cycle after bypass is set, which is MUX_CYC+2 cycles after bias_en rose. pwr_dn then stays high for exactly PD_CYC cycles. PD_CYC is PD_NS × CLKIN_KHZ / 10^6, rounded up (615 for 5000 ns at 122880 kHz).
- R4: Warm path (bypass=0 when start is accepted). mux_en falls on the accepting edge. bias_en, pwr_dn and bypass do not rise. No divider request is issued until at least MUX_CYC+1 cycles after mux_en falls.
- R5: The multiplier is stored as M−1. mult_lo holds bits 5:0 of M−1 and mult_hi holds bits 12:6.
- R6: The bandwidth value is (M/2 rounded down, but at least 1) minus 1, a 12-bit value. bw_lo holds bits 7:0 and bw_hi holds bits 11:8.
- R7: rdiv_fld holds D−1 and odiv_fld holds OD−1. All field outputs change only while reprogramming and keep the values of the last completed run.
- R8: The block issues a divider update only when go_busy is low. go_req is a single-cycle pulse, exactly one per run. pll_rst does not rise until go_busy has fallen again after the request.
- R9: pll_rst stays high for exactly RST_CYC cycles. mux_en rises exactly LOCK_CYC+1 cycles after pll_rst falls. bypass is already clear at that point, on the cold path exactly one cycle earlier. done rises together with mux_en, and busy is 0 from then on.
- R10: On the edge where done rises, both key slots are cleared. A following start with no new key writes is ignored.
- R11: A start pulse while busy is ignored. The run continues with the configuration that was captured first, and only one divider request is made.
- R12: An accepted start with M, D or OD equal to zero sets err and starts no run. The next accepted start with valid values clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a reprogramming run |
| cfg_mult | input | 13 | Target multiplier M |
| cfg_refdiv | input | 6 | Reference divider D |
| cfg_outdiv | input | 4 | Output divider OD |
| key_wr | input | 1 | Key slot write strobe |
| key_sel | input | 1 | Key slot select |
| key_data | input | 32 | Key slot write data |
| go_busy | input | 1 | Divider bank update in progress |
| go_req | output | 1 | Divider bank update request pulse |
| bias_en | output | 1 | PLL analog bias enable |
| mux_en | output | 1 | Clock mux selects PLL path when 1 |
| bypass | output | 1 | PLL bypass |
| pwr_dn | output | 1 | PLL power-down |
| pll_rst | output | 1 | PLL reset |
| mult_lo | output | 6 | Bits 5:0 of M−1 |
| mult_hi | output | 7 | Bits 12:6 of M−1 |
| bw_lo | output | 8 | Bits 7:0 of bandwidth value |
| bw_hi | output | 4 | Bits 11:8 of bandwidth value |
| rdiv_fld | output | 6 | D−1 |
| odiv_fld | output | 4 | OD−1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed, PLL in clock path |
| err | output | 1 | Last accepted start had a zero field |

## Verification
The bench goes after these corner cases:
- **Path choice.** The first run after reset must power-cycle the PLL, and every later run must not. A block that tested the wrong polarity of bypass would power down a locked PLL, or leave a cold one unbiased.
- **Field packing.** Vectors put M−1 at exactly 63 and at its 13-bit maximum, and use M=1 for the bandwidth floor. A mis-split field or a missing minus-one shows up directly on the field outputs.
- **Divider handshake.** go_busy is held high before the request is due. A sequencer that ignored it would request while the bank is busy, or reset the PLL mid-update.
- **Key slots.** Partial, wrong and cleared keys are tried, and a start is sent after completion. A block without relock would start a second run on its own.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int MULT_W = 13;
  localparam int RDIV_W = 6;
  localparam int ODIV_W = 4;
  localparam int BW_W   = 12;
  localparam int KEY_W  = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BIAS,
    ST_MUX_WAIT,
    ST_BYP_SET,
    ST_PD_WAIT,
    ST_PROG,
    ST_GO_IDLE,
    ST_GO_REQ,
    ST_GO_SETTLE,
    ST_GO_WAIT,
    ST_RST_WAIT,
    ST_LOCK_WAIT,
    ST_BYP_CLR
  } seq_state_e;

  typedef struct packed {
    logic [5:0] m_lo;
    logic [6:0] m_hi;
    logic [7:0] bw_lo;
    logic [3:0] bw_hi;
    logic [RDIV_W-1:0] rdiv;
    logic [ODIV_W-1:0] odiv;
  } pll_fields_t;

  // Bandwidth value: half the multiplier, floored at one, then minus one.
  function automatic logic [BW_W-1:0] bw_code(input logic [MULT_W-1:0] m);
    logic [BW_W-1:0] half;
    half = (m < MULT_W'(2)) ? BW_W'(1) : BW_W'(m >> 1);
    return half - BW_W'(1);
  endfunction

  function automatic pll_fields_t encode_fields(input logic [MULT_W-1:0] m,
                                                input logic [RDIV_W-1:0] d,
                                                input logic [ODIV_W-1:0] od);
    pll_fields_t f;
    logic [MULT_W-1:0] mm;
    logic [BW_W-1:0]   bw;
    mm     = m - MULT_W'(1);
    bw     = bw_code(m);
    f.m_lo  = mm[5:0];
    f.m_hi  = mm[12:6];
    f.bw_lo = bw[7:0];
    f.bw_hi = bw[11:8];
    f.rdiv  = d - RDIV_W'(1);
    f.odiv  = od - ODIV_W'(1);
    return f;
  endfunction

  function automatic logic cfg_valid(input logic [MULT_W-1:0] m,
                                     input logic [RDIV_W-1:0] d,
                                     input logic [ODIV_W-1:0] od);
    return (m != '0) && (d != '0) && (od != '0);
  endfunction

  function automatic int ns_to_cycles(input int khz, input int ns);
    return (khz * ns + 999999) / 1000000;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    if (d > r) r = d;
    return r;
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  // Loading N keeps the wait state for exactly N cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val - TW'(1);
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pll_seq_encode.sv
module pll_seq_encode
  import pll_seq_pkg::*;
(
  input  logic [MULT_W-1:0] mult,
  input  logic [RDIV_W-1:0] rdiv,
  input  logic [ODIV_W-1:0] odiv,
  output pll_fields_t       fields
);
  always_comb fields = encode_fields(mult, rdiv, odiv);
endmodule

// File: rtl/pll_seq_keygate.sv
module pll_seq_keygate #(
  parameter int KW = 32,
  parameter logic [KW-1:0] KEY_A = '0,
  parameter logic [KW-1:0] KEY_B = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [KW-1:0] data,
  input  logic          relock,
  output logic          unlocked
);
  logic [KW-1:0] slot [2];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot[g] <= '0;
      else if (relock)                   slot[g] <= '0;
      else if (wr && (sel == 1'(g)))     slot[g] <= data;
    end
  end

  assign unlocked = (slot[0] == KEY_A) && (slot[1] == KEY_B);
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int CLKIN_KHZ = 122880,
  parameter int PD_NS     = 5000,
  parameter int MUX_CYC   = 4,
  parameter int RST_CYC   = 128,
  parameter int LOCK_CYC  = 2000,
  parameter logic [31:0] KEY0 = 32'hC0DE_5A17,
  parameter logic [31:0] KEY1 = 32'h7E11_A93B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [12:0] cfg_mult,
  input  logic [5:0]  cfg_refdiv,
  input  logic [3:0]  cfg_outdiv,
  input  logic        key_wr,
  input  logic        key_sel,
  input  logic [31:0] key_data,
  input  logic        go_busy,
  output logic        go_req,
  output logic        bias_en,
  output logic        mux_en,
  output logic        bypass,
  output logic        pwr_dn,
  output logic        pll_rst,
  output logic [5:0]  mult_lo,
  output logic [6:0]  mult_hi,
  output logic [7:0]  bw_lo,
  output logic [3:0]  bw_hi,
  output logic [5:0]  rdiv_fld,
  output logic [3:0]  odiv_fld,
  output logic        busy,
  output logic        done,
  output logic        err
);
  localparam int PD_CYC   = ns_to_cycles(CLKIN_KHZ, PD_NS);
  localparam int WAIT_MAX = max4(MUX_CYC, PD_CYC, RST_CYC, LOCK_CYC);
  localparam int TW       = $clog2(WAIT_MAX + 1);

  seq_state_e        state;
  logic              cold_q;
  logic [MULT_W-1:0] mult_q;
  logic [RDIV_W-1:0] rdiv_q;
  logic [ODIV_W-1:0] odiv_q;
  pll_fields_t       fields_q;
  pll_fields_t       fields_enc;

  // Named internal events, observed by the checker.
  logic unlocked;
  logic start_acc;
  logic cfg_ok;
  logic t_expired;
  logic t_load;
  logic [TW-1:0] t_val;
  logic relock;

  assign cfg_ok    = cfg_valid(cfg_mult, cfg_refdiv, cfg_outdiv);
  assign start_acc = start && unlocked && (state == ST_IDLE);
  assign relock    = (state == ST_BYP_CLR);
  assign busy      = (state != ST_IDLE);
  assign go_req    = (state == ST_GO_REQ);

  pll_seq_keygate #(.KW(KEY_W), .KEY_A(KEY0), .KEY_B(KEY1)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr(key_wr), .sel(key_sel), .data(key_data),
    .relock(relock), .unlocked(unlocked)
  );

  pll_seq_encode u_enc (
    .mult(mult_q), .rdiv(rdiv_q), .odiv(odiv_q), .fields(fields_enc)
  );

  pll_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  // Pick which wait to start, if any, on this edge.
  always_comb begin
    t_load = 1'b0;
    t_val  = TW'(MUX_CYC);
    unique case (state)
      ST_IDLE: if (start_acc && cfg_ok && !bypass) t_load = 1'b1;
      ST_BIAS: t_load = 1'b1;
      ST_BYP_SET: begin t_load = 1'b1; t_val = TW'(PD_CYC); end
      ST_GO_WAIT: if (!go_busy) begin t_load = 1'b1; t_val = TW'(RST_CYC); end
      ST_RST_WAIT: if (t_expired) begin t_load = 1'b1; t_val = TW'(LOCK_CYC); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bias_en  <= 1'b0;
      mux_en   <= 1'b0;
      bypass   <= 1'b1;
      pwr_dn   <= 1'b0;
      pll_rst  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      cold_q   <= 1'b0;
      mult_q   <= '0;
      rdiv_q   <= '0;
      odiv_q   <= '0;
      fields_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_acc) begin
            if (!cfg_ok) begin
              err <= 1'b1;
            end else begin
              err    <= 1'b0;
              done   <= 1'b0;
              mult_q <= cfg_mult;
              rdiv_q <= cfg_refdiv;
              odiv_q <= cfg_outdiv;
              cold_q <= bypass;
              if (bypass) begin
                bias_en <= 1'b1;
                state   <= ST_BIAS;
              end else begin
                mux_en <= 1'b0;
                state  <= ST_MUX_WAIT;
              end
            end
          end
        end
        ST_BIAS: begin
          mux_en <= 1'b0;
          state  <= ST_MUX_WAIT;
        end
        ST_MUX_WAIT: begin
          if (t_expired) begin
            if (cold_q) begin
              bypass <= 1'b1;
              state  <= ST_BYP_SET;
            end else begin
              state <= ST_PROG;
            end
          end
        end
        ST_BYP_SET: begin
          pwr_dn <= 1'b1;
          state  <= ST_PD_WAIT;
        end
        ST_PD_WAIT: begin
          if (t_expired) begin
            pwr_dn <= 1'b0;
            state  <= ST_PROG;
          end
        end
        ST_PROG: begin
          fields_q <= fields_enc;
          state    <= ST_GO_IDLE;
        end
        ST_GO_IDLE:   if (!go_busy) state <= ST_GO_REQ;
        ST_GO_REQ:    state <= ST_GO_SETTLE;
        ST_GO_SETTLE: state <= ST_GO_WAIT;
        ST_GO_WAIT: begin
          if (!go_busy) begin
            pll_rst <= 1'b1;
            state   <= ST_RST_WAIT;
          end
        end
        ST_RST_WAIT: begin
          if (t_expired) begin
            pll_rst <= 1'b0;
            state   <= ST_LOCK_WAIT;
          end
        end
        ST_LOCK_WAIT: begin
          if (t_expired) begin
            bypass <= 1'b0;
            state  <= ST_BYP_CLR;
          end
        end
        ST_BYP_CLR: begin
          mux_en <= 1'b1;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mult_lo  = fields_q.m_lo;
  assign mult_hi  = fields_q.m_hi;
  assign bw_lo    = fields_q.bw_lo;
  assign bw_hi    = fields_q.bw_hi;
  assign rdiv_fld = fields_q.rdiv;
  assign odiv_fld = fields_q.odiv;
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
  parameter int PD_CYC  = 615,
  parameter int RST_CYC = 128
) (
  input logic clk,
  input logic rst_n,
  input logic go_busy,
  input logic go_req,
  input logic bias_en,
  input logic mux_en,
  input logic bypass,
  input logic pwr_dn,
  input logic pll_rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic unlocked
);
  logic [31:0] pd_run;
  logic [31:0] rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_run  <= '0;
      rst_run <= '0;
    end else begin
      pd_run  <= pwr_dn  ? pd_run + 32'd1  : 32'd0;
      rst_run <= pll_rst ? rst_run + 32'd1 : 32'd0;
    end
  end

  AST_PD_UNDER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (bypass && bias_en && !mux_en)) else $error("pd outside bypass"); // R3
  AST_PD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn) |-> (pd_run == 32'(PD_CYC))) else $error("pd width"); // R3
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |=> !go_req) else $error("go pulse"); // R8
  AST_GO_MUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    go_req |-> !mux_en) else $error("go while mux on"); // R4
  AST_RST_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst) |-> $past(!go_busy)) else $error("reset during update"); // R8
  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> (rst_run == 32'(RST_CYC))) else $error("rst width"); // R9
  AST_MUX_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_en) |-> (!bypass && !pll_rst && done)) else $error("mux order"); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R9
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !unlocked) else $error("not relocked"); // R10
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy) else $error("err with run"); // R12
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(.PD_CYC(PD_CYC), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_busy(go_busy), .go_req(go_req), .bias_en(bias_en),
  .mux_en(mux_en), .bypass(bypass), .pwr_dn(pwr_dn), .pll_rst(pll_rst), .busy(busy),
  .done(done), .err(err), .unlocked(unlocked)
);

// File: tb/pll_bringup_seq_test.sv
module pll_bringup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K0 = 32'hC0DE_5A17;
  localparam logic [31:0] K1 = 32'h7E11_A93B;
  localparam int MUXW = 4;
  localparam int RSTW = 128;
  localparam int LOCKW = 2000;
  localparam int PDW = 615;   // 122.88 MHz x 5 us = 614.4 cycles, rounded up

  // {M, D, OD}
  localparam logic [22:0] VEC [6] = '{
    {13'd16,   6'd1,  4'd2},
    {13'd625,  6'd32, 4'd2},
    {13'd8191, 6'd63, 4'd15},
    {13'd1,    6'd1,  4'd1},
    {13'd64,   6'd2,  4'd4},
    {13'd20,   6'd1,  4'd2}
  };

  logic clk = 0, rst_n = 0, start = 0, key_wr = 0, key_sel = 0;
  logic [12:0] cfg_mult = 0;
  logic [5:0] cfg_refdiv = 0;
  logic [3:0] cfg_outdiv = 0;
  logic [31:0] key_data = 0;
  logic go_busy, go_req, bias_en, mux_en, bypass, pwr_dn, pll_rst, busy, done, err;
  logic [5:0] mult_lo; logic [6:0] mult_hi; logic [7:0] bw_lo; logic [3:0] bw_hi;
  logic [5:0] rdiv_fld; logic [3:0] odiv_fld;
  logic hold_busy = 0;
  int busy_ctr;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_bringup_seq #(.KEY0(K0), .KEY1(K1)) uut (
    .clk, .rst_n, .start, .cfg_mult, .cfg_refdiv, .cfg_outdiv, .key_wr, .key_sel,
    .key_data, .go_busy, .go_req, .bias_en, .mux_en, .bypass, .pwr_dn, .pll_rst,
    .mult_lo, .mult_hi, .bw_lo, .bw_hi, .rdiv_fld, .odiv_fld, .busy, .done, .err
  );

  // Divider bank model: busy for 5 cycles after a request.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) busy_ctr <= 0;
    else if (go_req) busy_ctr <= 5;
    else if (busy_ctr != 0) busy_ctr <= busy_ctr - 1;
  end
  assign go_busy = (busy_ctr != 0) || hold_busy;

  // Event monitor.
  int t_bias, t_muxf, t_muxr, t_pdr, t_pdf, t_rstr, t_rstf, t_bypf, t_go, t_busyf;
  int n_pd, n_byp_rise, n_go;
  logic p_bias = 0, p_mux = 0, p_pd = 0, p_rst = 0, p_byp = 1, p_busy = 0;

  task automatic clear_mon();
    t_bias = -1; t_muxf = -1; t_muxr = -1; t_pdr = -1; t_pdf = -1; t_rstr = -1;
    t_rstf = -1; t_bypf = -1; t_go = -1; t_busyf = -1;
    n_pd = 0; n_byp_rise = 0; n_go = 0;
  endtask

  always @(negedge clk) begin
    if (bias_en && !p_bias) t_bias = cyc;
    if (!mux_en && p_mux) t_muxf = cyc;
    if (mux_en && !p_mux) t_muxr = cyc;
    if (pwr_dn && !p_pd) begin t_pdr = cyc; n_pd++; end
    if (!pwr_dn && p_pd) t_pdf = cyc;
    if (pll_rst && !p_rst) t_rstr = cyc;
    if (!pll_rst && p_rst) t_rstf = cyc;
    if (bypass && !p_byp) n_byp_rise++;
    if (!bypass && p_byp) t_bypf = cyc;
    if (go_req) begin t_go = cyc; n_go++; end
    if (!go_busy && p_busy) t_busyf = cyc;
    p_bias = bias_en; p_mux = mux_en; p_pd = pwr_dn; p_rst = pll_rst;
    p_byp = bypass; p_busy = go_busy;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_key(input bit sel, input logic [31:0] v);
    @(negedge clk); key_wr = 1; key_sel = sel; key_data = v;
    @(negedge clk); key_wr = 0;
  endtask

  task automatic unlock();
    write_key(0, K0); write_key(1, K1);
  endtask

  task automatic pulse_start(input logic [12:0] m, input logic [5:0] d, input logic [3:0] od);
    @(negedge clk); cfg_mult = m; cfg_refdiv = d; cfg_outdiv = od; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 8000 && !done; n++) @(negedge clk);
    check(done == 1, "R9", "done reached", done, 1);
    @(negedge clk);
  endtask

  task automatic check_fields(input logic [12:0] m, input logic [5:0] d, input logic [3:0] od);
    int mm, bw;
    mm = m - 1;
    bw = (m / 2 == 0 ? 1 : m / 2) - 1;
    check(mult_lo == mm % 64, "R5", "mult_lo", mult_lo, mm % 64);
    check(mult_hi == mm / 64, "R5", "mult_hi", mult_hi, mm / 64);
    check(bw_lo == bw % 256, "R6", "bw_lo", bw_lo, bw % 256);
    check(bw_hi == bw / 256, "R6", "bw_hi", bw_hi, bw / 256);
    check(rdiv_fld == d - 1, "R7", "rdiv", rdiv_fld, d - 1);
    check(odiv_fld == od - 1, "R7", "odiv", odiv_fld, od - 1);
  endtask

  task automatic check_tail();
    check(n_go == 1, "R8", "go count", n_go, 1);
    check(t_busyf > t_go, "R8", "busy fall after go", t_busyf, t_go + 1);
    check(t_rstr > t_busyf, "R8", "rst after busy fall", t_rstr, t_busyf + 1);
    check(t_rstf - t_rstr == RSTW, "R9", "rst width", t_rstf - t_rstr, RSTW);
    check(t_muxr - t_rstf == LOCKW + 1, "R9", "lock to mux", t_muxr - t_rstf, LOCKW + 1);
    check(!bypass && mux_en && !busy, "R9", "final pins", {bypass, mux_en, busy}, 3'b010);
  endtask

  task automatic run_seq(input logic [12:0] m, input logic [5:0] d, input logic [3:0] od,
                         input bit cold);
    unlock();
    clear_mon();
    pulse_start(m, d, od);
    wait_done();
    if (cold) begin
      check(t_pdr - t_bias == MUXW + 2, "R3", "bias to pd", t_pdr - t_bias, MUXW + 2);
      check(t_pdf - t_pdr == PDW, "R3", "pd width", t_pdf - t_pdr, PDW);
      check(t_bypf - t_rstf == LOCKW, "R9", "lock to bypass clear", t_bypf - t_rstf, LOCKW);
    end else begin
      check(n_pd == 0 && t_bias == -1 && n_byp_rise == 0, "R4", "no cold actions",
            n_pd + n_byp_rise, 0);
      check(t_muxf >= 0 && t_go - t_muxf >= MUXW + 1, "R4", "mux off to go",
            t_go - t_muxf, MUXW + 1);
    end
    check_tail();
    check_fields(m, d, od);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(bypass == 1, "R1", "bypass", bypass, 1);
    check({bias_en, mux_en, pwr_dn, pll_rst, go_req, busy, done, err} == 0, "R1", "ctrl",
          {bias_en, mux_en, pwr_dn, pll_rst, go_req, busy, done, err}, 0);
    check({mult_lo, mult_hi, bw_lo, bw_hi, rdiv_fld, odiv_fld} == 0, "R1", "fields",
          {mult_lo, mult_hi, bw_lo, bw_hi, rdiv_fld, odiv_fld}, 0);

    // R2 lock gate
    pulse_start(16, 1, 2); @(negedge clk);
    check(!busy && !bias_en, "R2", "no keys", busy, 0);
    write_key(0, K0);
    pulse_start(16, 1, 2); @(negedge clk);
    check(!busy && !bias_en, "R2", "one key", busy, 0);
    write_key(1, K1 ^ 32'h1);
    pulse_start(16, 1, 2); @(negedge clk);
    check(!busy && !bias_en, "R2", "wrong key", busy, 0);
    unlock(); write_key(0, 32'h0);
    pulse_start(16, 1, 2); @(negedge clk);
    check(!busy && !bias_en, "R2", "key cleared", busy, 0);

    // R12 zero fields
    unlock();
    pulse_start(0, 1, 2);
    check(err && !busy && !bias_en, "R12", "M zero", {err, busy}, 2'b10);
    pulse_start(16, 0, 2);
    check(err && !busy, "R12", "D zero", {err, busy}, 2'b10);
    pulse_start(16, 1, 0);
    check(err && !busy, "R12", "OD zero", {err, busy}, 2'b10);

    // Table: first run is cold, the rest warm.
    for (int i = 0; i < 6; i++) begin
      run_seq(VEC[i][22:10], VEC[i][9:4], VEC[i][3:0], i == 0);
      if (i == 0) check(err == 0, "R12", "err cleared", err, 0);
    end

    // R10 relock after completion
    pulse_start(22, 1, 2); @(negedge clk);
    check(!busy && mux_en, "R10", "start after done ignored", busy, 0);

    // R8 divider bank busy before request
    unlock(); clear_mon(); hold_busy = 1;
    pulse_start(12, 1, 2);
    repeat (40) @(negedge clk);
    check(n_go == 0, "R8", "no go while busy", n_go, 0);
    hold_busy = 0;
    wait_done();
    check_tail();

    // R11 start while busy
    unlock(); clear_mon();
    pulse_start(10, 1, 2);
    repeat (20) @(negedge clk);
    pulse_start(50, 3, 5);
    wait_done();
    check(n_go == 1, "R11", "single go", n_go, 1);
    check_fields(10, 1, 2);
    check(mult_lo == 9, "R11", "first cfg kept", mult_lo, 9);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule